// File: doc/BRIEF.md
# Serial Control Register Write Port

This block receives a five-bit control word from a host over a three-wire serial link: an active-low frame select, a serial clock and a data line. All three wires are brought into the system clock domain through a synchroniser, and falling serial-clock edges are detected there. Each frame shifts in a channel address, a software convert flag and a standby flag.

A write counts only once enough clock edges have arrived inside one frame. The channel address and convert flag commit on the sixth falling edge. The standby flag commits only on the seventh. A frame that closes early leaves every field as it was. The one exception is a convert request: if the convert flag has already been shifted in, the request still fires when the frame closes. Two one-cycle strobes tell the downstream conversion controller that an address was loaded and that a software conversion was asked for.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, chan_o, sw_conv_o and stby_o are 0, and addr_load_o and conv_req_o are low.
- R2: Only falling serial-clock edges taken while fs_ni is low shift in data, most significant bit first. Edges 1 to 5 carry, in order: chan bit 2, chan bit 1, chan bit 0, the convert flag and the standby flag.
- R3: On the sixth falling edge of a frame, chan_o and sw_conv_o take the received values, and addr_load_o pulses high for exactly one cycle.
- R4: A frame that ends with fewer than six falling edges leaves chan_o, sw_conv_o and stby_o unchanged and gives no addr_load_o pulse.
- R5: stby_o takes the received standby flag only on the seventh falling edge. A frame with exactly six edges leaves stby_o unchanged.
- R6: On the sixth edge, conv_req_o pulses for one cycle exactly when the received convert flag is 1.
- R7: A frame that ends after the fourth or fifth edge with a received convert flag of 1 gives a single one-cycle conv_req_o pulse at frame end. A frame that ends after three or fewer edges, or with the flag at 0, gives no pulse.
- R8: The edge count restarts every frame. Falling edges after the seventh change nothing, and the next frame begins again at chan bit 2.
- R9: Serial-clock edges while fs_ni is high shift in nothing and change no output.
- R10: An output caused by a falling edge changes on the third rising clk edge that samples the new serial-clock level, counting the one that first samples it as the first (two synchroniser stages plus one register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_ni | input | 1 | Frame select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous; data taken on its falling edge |
| sdi_i | input | 1 | Serial data |
| chan_o | output | 3 | Committed channel address |
| sw_conv_o | output | 1 | Committed software convert flag |
| stby_o | output | 1 | Committed standby flag |
| addr_load_o | output | 1 | One-cycle strobe: a valid write has loaded the address |
| conv_req_o | output | 1 | One-cycle strobe: a software conversion is requested |

## Verification
The assertions rely on each serial-clock level being held for at least two system clock cycles. This keeps falling edges far enough apart that a commit, a standby commit and a frame-end abort can never land in the same cycle or in back-to-back cycles. The stimulus holds every serial-clock half period for four clk cycles. It changes data and frame select only while the serial clock is high, and it leaves idle gaps between frames. Every input is driven on the falling clk edge, so each level is sampled cleanly.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int unsigned CHAN_W = 3;
  localparam int unsigned WORD_W = CHAN_W + 2;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              conv;
    logic              stby;
  } ctl_word_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned         WIDTH   = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
  import ctl_port_pkg::*;
#(
  parameter int unsigned COMMIT_EDGE = 6,
  parameter int unsigned STBY_EDGE   = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fs_n_i,
  input  logic      sck_i,
  input  logic      sdi_i,
  output ctl_word_t word_o,
  output logic      commit_o,
  output logic      stby_commit_o,
  output logic      abort_conv_o
);
  localparam int unsigned CNT_W = $clog2(STBY_EDGE + 1);

  logic             sck_q, fs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic             fall, edge_ok;

  assign fall    = sck_q & ~sck_i;
  assign edge_ok = ~fs_n_i & fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1;
      fs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      fs_q  <= fs_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (fs_n_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (fall) begin
      for (int b = 0; b < int'(WORD_W); b++)
        if (cnt_q == CNT_W'(b)) sh_q[WORD_W-1-b] <= sdi_i;
      if (cnt_q < CNT_W'(STBY_EDGE)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o        = ctl_word_t'(sh_q);
  assign commit_o      = edge_ok && (cnt_q == CNT_W'(COMMIT_EDGE - 1));
  assign stby_commit_o = edge_ok && (cnt_q == CNT_W'(STBY_EDGE - 1));
  // frame closed early after the convert flag arrived
  assign abort_conv_o  = fs_n_i && !fs_q && word_o.conv &&
                         (cnt_q >= CNT_W'(WORD_W - 1)) &&
                         (cnt_q <  CNT_W'(COMMIT_EDGE));

  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_n_i |=> (cnt_q == '0));
  p_one_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_o, stby_commit_o, abort_conv_o}));
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg
  import ctl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_word_t         word_i,
  input  logic              commit_i,
  input  logic              stby_commit_i,
  input  logic              abort_conv_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              conv_o,
  output logic              stby_o,
  output logic              addr_load_o,
  output logic              conv_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o      <= '0;
      conv_o      <= 1'b0;
      stby_o      <= 1'b0;
      addr_load_o <= 1'b0;
      conv_req_o  <= 1'b0;
    end else begin
      addr_load_o <= commit_i;
      conv_req_o  <= (commit_i && word_i.conv) || abort_conv_i;
      if (commit_i) begin
        chan_o <= word_i.chan;
        conv_o <= word_i.conv;
      end
      if (stby_commit_i) stby_o <= word_i.stby;
    end
  end

  p_hold_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(chan_o) && $stable(conv_o)));
  p_stby_late_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_commit_i |=> $stable(stby_o));
  p_load_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_o |=> !addr_load_o);
  p_conv_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned COMMIT_EDGE = 6,
  parameter int unsigned STBY_EDGE   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              sw_conv_o,
  output logic              stby_o,
  output logic              addr_load_o,
  output logic              conv_req_o
);
  logic [2:0] pins_s;
  ctl_word_t  word;
  logic       commit, stby_commit, abort_conv;

  ctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fs_ni, sck_i, sdi_i}),
    .q_o   (pins_s)
  );

  ctl_frame_rx #(.COMMIT_EDGE(COMMIT_EDGE), .STBY_EDGE(STBY_EDGE)) i_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fs_n_i       (pins_s[2]),
    .sck_i        (pins_s[1]),
    .sdi_i        (pins_s[0]),
    .word_o       (word),
    .commit_o     (commit),
    .stby_commit_o(stby_commit),
    .abort_conv_o (abort_conv)
  );

  ctl_reg i_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (word),
    .commit_i     (commit),
    .stby_commit_i(stby_commit),
    .abort_conv_i (abort_conv),
    .chan_o       (chan_o),
    .conv_o       (sw_conv_o),
    .stby_o       (stby_o),
    .addr_load_o  (addr_load_o),
    .conv_req_o   (conv_req_o)
  );

  p_conv_matches_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_o |-> (conv_req_o == sw_conv_o));
endmodule

// File: tb/test_ctl_serial_port.sv
module test_ctl_serial_port;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 50000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic [2:0] chan;
  logic sw_conv, stby, addr_load, conv_req;

  int vecs = 0, fails = 0, cyc = 0;
  int al_cnt = 0, cr_cnt = 0, lat_drive = 0, lat_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_serial_port i_ctl_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .fs_ni(fs_n), .sck_i(sck), .sdi_i(sdi),
    .chan_o(chan), .sw_conv_o(sw_conv), .stby_o(stby),
    .addr_load_o(addr_load), .conv_req_o(conv_req)
  );

  // behavioural reference: inputs seen two edges late, edge vs. three edges late
  logic [2:0] h_a = 3'b110, h_b = 3'b110, h_c = 3'b110;
  int   m_cnt = 0;
  logic [4:0] m_word = '0;
  logic [2:0] m_chan = '0;
  logic m_conv = 0, m_stby = 0, m_al = 0, m_cr = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      h_a = 3'b110; h_b = 3'b110; h_c = 3'b110;
      m_cnt = 0; m_word = '0; m_chan = '0;
      m_conv = 0; m_stby = 0; m_al = 0; m_cr = 0;
    end else begin
      m_al = 0; m_cr = 0;
      if (!h_b[2]) begin
        if (h_c[1] && !h_b[1]) begin
          if (m_cnt < 5) m_word[4-m_cnt] = h_b[0];
          if (m_cnt == 5) begin
            m_chan = m_word[4:2]; m_conv = m_word[1];
            m_al = 1; m_cr = m_word[1];
          end
          if (m_cnt == 6) m_stby = m_word[0];
          if (m_cnt < 7) m_cnt++;
        end
      end else begin
        if (!h_c[2] && m_cnt >= 4 && m_cnt < 6 && m_word[1]) m_cr = 1;
        m_cnt = 0; m_word = '0;
      end
      h_c = h_b; h_b = h_a; h_a = {fs_n, sck, sdi};
    end
  end

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 chan",       chan,      m_chan);
    chk("R3 sw_conv",    sw_conv,   m_conv);
    chk("R5 stby",       stby,      m_stby);
    chk("R10 addr_load", addr_load, m_al);
    chk("R7 conv_req",   conv_req,  m_cr);
    if (addr_load) begin al_cnt++; lat_seen = cyc; end
    if (conv_req) cr_cnt++;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [4:0] w, int edges, logic fill);
    al_cnt = 0; cr_cnt = 0;
    fs_n = 1'b0;
    wait_n(4);
    for (int e = 0; e < edges; e++) begin
      sdi = (e < 5) ? w[4-e] : fill;
      wait_n(2);
      sck = 1'b0;
      if (e == 5) lat_drive = cyc;
      wait_n(4);
      sck = 1'b1;
      wait_n(2);
    end
    wait_n(4);
    fs_n = 1'b1;
    wait_n(12);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 chan", chan, 0); chk("R1 conv", sw_conv, 0); chk("R1 stby", stby, 0);
    chk("R1 strobes", addr_load | conv_req, 0);

    send(5'b101_0_0, 7, 1'b0);
    chk("R2 chan", chan, 5); chk("R3 load once", al_cnt, 1); chk("R6 no req", cr_cnt, 0);
    chk("R10 latency", lat_seen - lat_drive, 3);

    send(5'b011_1_1, 6, 1'b0);
    chk("R3 chan", chan, 3); chk("R3 conv", sw_conv, 1);
    chk("R5 stby held", stby, 0); chk("R6 req", cr_cnt, 1);

    send(5'b110_0_1, 7, 1'b0);
    chk("R5 stby set", stby, 1); chk("R2 chan", chan, 6); chk("R3 conv", sw_conv, 0);

    send(5'b001_1_0, 3, 1'b0);
    chk("R4 chan held", chan, 6); chk("R4 no load", al_cnt, 0); chk("R7 no req", cr_cnt, 0);

    send(5'b010_1_0, 5, 1'b0);
    chk("R4 chan held", chan, 6); chk("R7 req 5 edges", cr_cnt, 1);
    chk("R4 conv held", sw_conv, 0); chk("R4 stby held", stby, 1);

    send(5'b010_1_0, 4, 1'b0);
    chk("R7 req 4 edges", cr_cnt, 1); chk("R4 no load", al_cnt, 0);

    send(5'b010_0_0, 5, 1'b0);
    chk("R7 flag zero", cr_cnt, 0);

    send(5'b111_0_0, 10, 1'b1);
    chk("R8 chan", chan, 7); chk("R8 stby", stby, 0); chk("R8 one load", al_cnt, 1);

    al_cnt = 0; cr_cnt = 0; sdi = 1'b1;
    for (int e = 0; e < 8; e++) begin
      sck = 1'b0; wait_n(4); sck = 1'b1; wait_n(4);
    end
    wait_n(6);
    chk("R9 chan", chan, 7); chk("R9 stby", stby, 0); chk("R9 strobes", al_cnt + cr_cnt, 0);

    send(5'b001_0_1, 7, 1'b0);
    chk("R8 restart chan", chan, 1); chk("R8 restart stby", stby, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule